// File: doc/BRIEF.md
# Single Burst-Write Command Sequencer for a 32-bit SDRAM

This block turns one write request into the full command sequence that a four-bank, 32-bit-wide SDRAM needs to store a burst of four words. It opens the row, issues the column write with auto-precharge turned off, and drives the four data words with their byte masks. It then waits out write recovery and the minimum row-active time and closes the bank with an explicit single-bank PRECHARGE. It keeps the requester stalled until the row-precharge and row-cycle minimums allow the next ACTIVE.

All waits are set by picosecond parameters and the clock period. Each is rounded up to whole clocks at elaboration. Write recovery is never shorter than two clocks. Elaboration stops if the row would stay open longer than the maximum row-active time. Every memory-side output comes from a register.

Top module: `sdr_wr_seq`

## Requirements
- R1: While reset is asserted and right after it, the command is NOP (select, row strobe, column strobe and write enable = 0,1,1,1), the data output enable is low, the byte mask is all ones, done is low and ready is high.
- R2: A request taken while ready is high makes the next cycle carry ACTIVE, with the row on the address bus and the bank on the bank outputs. Ready is low in that cycle. ACTIVE encodes as 0,0,1,1.
- R3: WRITE (0,1,0,0) follows ACTIVE after the row-to-column delay: one cycle at the default parameters. It carries the column zero-extended on the address bus, so the auto-precharge bit (address bit 10) is low, and it carries the same bank.
- R4: The four data words appear on consecutive cycles starting with the WRITE cycle, word 0 first. Word k is request data bits [32k+31:32k]. The output enable is high in exactly those four cycles. The byte mask in each of them is request mask bits [4k+3:4k], where a 1 blocks that byte. In every other cycle the byte mask is all ones.
- R5: PRECHARGE (0,0,1,0) comes at the later of two points: the minimum row-active time after ACTIVE, or the write-recovery time after the last data word. That is six cycles after ACTIVE at the defaults. It has address bit 10 low and the bank of the ACTIVE.
- R6: Done is high for exactly the one cycle that carries PRECHARGE.
- R7: Ready returns high late enough that the next ACTIVE meets both the precharge-to-active and the active-to-active minimums. At the defaults ready is high in the PRECHARGE cycle, and a request held there gets its ACTIVE seven cycles after the previous one.
- R8: A request presented while ready is low is ignored. The command sequence, address, bank, data and masks of the write in progress are unchanged.
- R9: Clock enable stays high. Every cycle that is not ACTIVE, WRITE or PRECHARGE carries NOP, including all idle cycles.
- R10: An asynchronous reset in the middle of a sequence returns the outputs to the R1 state. The next request then runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request will be taken this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | 11 | Row to open |
| req_col | input | 8 | Starting column |
| req_data | input | 128 | Four data words, word 0 in the low bits |
| req_mask | input | 16 | Four byte masks, word 0 in the low bits, 1 blocks a byte |
| done | output | 1 | One-cycle pulse with PRECHARGE |
| mem_clk_en | output | 1 | Memory clock enable |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_row_stb_n | output | 1 | Row strobe, active low |
| mem_col_stb_n | output | 1 | Column strobe, active low |
| mem_wr_en_n | output | 1 | Write enable, active low |
| mem_addr | output | 11 | Multiplexed row/column address |
| mem_bank | output | 2 | Bank address |
| mem_dq_o | output | 32 | Write data |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_byte_mask | output | 4 | Per-byte write mask |

## Verification
The properties assume that the requester follows the ready/valid rule. A request counts only when valid and ready are high together. The timing checks measure gaps from the ACTIVE that the block itself issued, so they also assume that nothing else drives commands to the memory. The stimulus keeps within these assumptions: it changes inputs only on the falling clock edge and never relies on a request being taken while ready is low. Its one deliberate request under low ready has scrambled fields, and those fields must not reach the bus.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;

   // Command code on {select, row strobe, column strobe, write enable}, all active low
   typedef enum logic [3:0] {
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   // Round a time up to whole clocks, with a lower bound
   function automatic int ps_to_ck(input int t_ps, input int tck_ps, input int floor_ck);
      int n;
      n = (t_ps + tck_ps - 1) / tck_ps;
      return (n < floor_ck) ? floor_ck : n;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_wr_timer.sv
// Slot counter: slot 0 is the ACTIVE cycle; saturates at END_SLOT when idle.
module sdr_wr_timer #(
   parameter int SLOT_W   = 3,
   parameter int END_SLOT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              accept,
   output logic [SLOT_W-1:0] slot_n,
   output logic              ready
);
   localparam logic [SLOT_W-1:0] END_V   = SLOT_W'(END_SLOT);
   localparam logic [SLOT_W-1:0] READY_V = SLOT_W'(END_SLOT - 1);

   logic [SLOT_W-1:0] slot_q;

   assign accept = req_valid & ready;

   always_comb begin
      if (accept)              slot_n = '0;
      else if (slot_q == END_V) slot_n = END_V;
      else                      slot_n = slot_q + SLOT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= END_V;
         ready  <= 1'b1;
      end else begin
         slot_q <= slot_n;
         ready  <= (slot_n >= READY_V);
      end
   end
endmodule

// File: rtl/sdr_wr_decode.sv
// Maps a slot number to a command and a data phase.
module sdr_wr_decode
   import sdr_wr_pkg::*;
#(
   parameter int SLOT_W    = 3,
   parameter int WIDX_W    = 2,
   parameter int BURST_LEN = 4,
   parameter int P_WR      = 1,
   parameter int P_PRE     = 6
) (
   input  logic [SLOT_W-1:0] slot,
   output sdr_cmd_e          cmd,
   output logic              data_phase,
   output logic [WIDX_W-1:0] word_idx
);
   localparam logic [SLOT_W-1:0] WR_V   = SLOT_W'(P_WR);
   localparam logic [SLOT_W-1:0] PRE_V  = SLOT_W'(P_PRE);
   localparam logic [SLOT_W-1:0] DEND_V = SLOT_W'(P_WR + BURST_LEN);

   always_comb begin
      if (slot == '0)        cmd = CMD_ACT;
      else if (slot == WR_V)  cmd = CMD_WR;
      else if (slot == PRE_V) cmd = CMD_PRE;
      else                    cmd = CMD_NOP;
      data_phase = (slot >= WR_V) && (slot < DEND_V);
      word_idx   = WIDX_W'(slot - WR_V);
   end
endmodule

// File: rtl/sdr_wr_pins.sv
// Registered memory-side outputs.
module sdr_wr_pins
   import sdr_wr_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int AP_BIT    = 10,
   parameter int ROW_W     = 11,
   parameter int COL_W     = 8,
   parameter int BA_W      = 2,
   parameter int DQ_W      = 32,
   parameter int MASK_W    = 4,
   parameter int BURST_LEN = 4,
   parameter int WIDX_W    = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  sdr_cmd_e                            cmd,
   input  logic                                data_phase,
   input  logic [WIDX_W-1:0]                   word_idx,
   input  logic [BA_W-1:0]                     bank,
   input  logic [ROW_W-1:0]                    row,
   input  logic [COL_W-1:0]                    col,
   input  logic [BURST_LEN-1:0][DQ_W-1:0]      words,
   input  logic [BURST_LEN-1:0][MASK_W-1:0]    masks,
   output sdr_cmd_e                            cmd_q,
   output logic [ADDR_W-1:0]                   addr_q,
   output logic [BA_W-1:0]                     ba_q,
   output logic [DQ_W-1:0]                     dq_q,
   output logic                                oe_q,
   output logic [MASK_W-1:0]                   dqm_q,
   output logic                                done_q
);
   logic [ADDR_W-1:0] addr_n;

   always_comb begin
      addr_n = '0;
      case (cmd)
         CMD_ACT: addr_n = ADDR_W'(row);
         CMD_WR: begin
            addr_n[COL_W-1:0] = col;
            addr_n[AP_BIT]    = 1'b0;   // no auto-precharge
         end
         default: addr_n = '0;          // PRECHARGE: bit AP_BIT low, one bank
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         ba_q   <= '0;
         dq_q   <= '0;
         oe_q   <= 1'b0;
         dqm_q  <= '1;
         done_q <= 1'b0;
      end else begin
         cmd_q  <= cmd;
         addr_q <= addr_n;
         ba_q   <= (cmd == CMD_NOP) ? '0 : bank;
         oe_q   <= data_phase;
         dq_q   <= data_phase ? words[word_idx] : '0;
         dqm_q  <= data_phase ? masks[word_idx] : '1;
         done_q <= (cmd == CMD_PRE);
      end
   end
endmodule

// File: rtl/sdr_wr_seq.sv
module sdr_wr_seq
   import sdr_wr_pkg::*;
#(
   parameter int TCK_PS        = 20000,
   parameter int T_RCD_PS      = 20000,
   parameter int T_RAS_PS      = 42000,
   parameter int T_RAS_MAX_PS  = 120000000,
   parameter int T_RP_PS       = 20000,
   parameter int T_RC_PS       = 60000,
   parameter int T_WR_PS       = 10000,
   parameter int WR_MIN_CK     = 2,
   parameter int BURST_LEN     = 4,
   parameter int ADDR_W        = 11,
   parameter int AP_BIT        = 10,
   parameter int ROW_W         = 11,
   parameter int COL_W         = 8,
   parameter int BA_W          = 2,
   parameter int DQ_W          = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [BA_W-1:0]               req_bank,
   input  logic [ROW_W-1:0]              req_row,
   input  logic [COL_W-1:0]              req_col,
   input  logic [BURST_LEN*DQ_W-1:0]     req_data,
   input  logic [BURST_LEN*DQ_W/8-1:0]   req_mask,
   output logic                          done,
   output logic                          mem_clk_en,
   output logic                          mem_sel_n,
   output logic                          mem_row_stb_n,
   output logic                          mem_col_stb_n,
   output logic                          mem_wr_en_n,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [BA_W-1:0]               mem_bank,
   output logic [DQ_W-1:0]               mem_dq_o,
   output logic                          mem_dq_oe,
   output logic [DQ_W/8-1:0]             mem_byte_mask
);
   localparam int MASK_W = DQ_W / 8;
   localparam int N_RCD  = ps_to_ck(T_RCD_PS, TCK_PS, 1);
   localparam int N_RAS  = ps_to_ck(T_RAS_PS, TCK_PS, 1);
   localparam int N_WR   = ps_to_ck(T_WR_PS, TCK_PS, WR_MIN_CK);
   localparam int N_RP   = ps_to_ck(T_RP_PS, TCK_PS, 1);
   localparam int N_RC   = ps_to_ck(T_RC_PS, TCK_PS, 1);
   localparam int P_WR   = N_RCD;
   localparam int P_LAST = P_WR + BURST_LEN - 1;
   localparam int P_PRE  = imax(N_RAS, P_LAST + N_WR);
   localparam int P_NEXT = imax(P_PRE + N_RP, N_RC);
   localparam int SLOT_W = $clog2(P_NEXT + 1);
   localparam int WIDX_W = $clog2(BURST_LEN);

   // Elaboration-time parameter checks
   if (BURST_LEN < 2)                  begin : g_bad_burst $error("BURST_LEN must be at least 2"); end
   if (DQ_W % 8 != 0)                  begin : g_bad_dq    $error("DQ_W must be whole bytes"); end
   if (ROW_W > ADDR_W)                 begin : g_bad_row   $error("row does not fit address bus"); end
   if (COL_W > AP_BIT)                 begin : g_bad_col   $error("column overlaps precharge bit"); end
   if (AP_BIT >= ADDR_W)               begin : g_bad_ap    $error("precharge bit outside address bus"); end
   if (P_PRE * TCK_PS > T_RAS_MAX_PS)  begin : g_bad_ras   $error("row open beyond maximum active time"); end

   logic              accept;
   logic [SLOT_W-1:0] slot_n;
   sdr_cmd_e          cmd_n, cmd_q;
   logic              data_phase;
   logic [WIDX_W-1:0] word_idx;

   logic [BURST_LEN-1:0][DQ_W-1:0]   req_words, words_q;
   logic [BURST_LEN-1:0][MASK_W-1:0] req_masks, masks_q;
   logic [BA_W-1:0]  bank_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   for (genvar k = 0; k < BURST_LEN; k++) begin : g_unpack
      assign req_words[k] = req_data[k*DQ_W +: DQ_W];
      assign req_masks[k] = req_mask[k*MASK_W +: MASK_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         words_q <= '0;
         masks_q <= '1;
      end else if (accept) begin
         bank_q  <= req_bank;
         row_q   <= req_row;
         col_q   <= req_col;
         words_q <= req_words;
         masks_q <= req_masks;
      end
   end

   sdr_wr_timer #(.SLOT_W(SLOT_W), .END_SLOT(P_NEXT)) u_timer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .accept(accept), .slot_n(slot_n), .ready(req_ready));

   sdr_wr_decode #(.SLOT_W(SLOT_W), .WIDX_W(WIDX_W), .BURST_LEN(BURST_LEN),
                   .P_WR(P_WR), .P_PRE(P_PRE)) u_dec (
      .slot(slot_n), .cmd(cmd_n), .data_phase(data_phase), .word_idx(word_idx));

   sdr_wr_pins #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .ROW_W(ROW_W), .COL_W(COL_W),
                 .BA_W(BA_W), .DQ_W(DQ_W), .MASK_W(MASK_W), .BURST_LEN(BURST_LEN),
                 .WIDX_W(WIDX_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_n), .data_phase(data_phase), .word_idx(word_idx),
      .bank(accept ? req_bank : bank_q), .row(accept ? req_row : row_q), .col(col_q),
      .words(words_q), .masks(masks_q),
      .cmd_q(cmd_q), .addr_q(mem_addr), .ba_q(mem_bank), .dq_q(mem_dq_o),
      .oe_q(mem_dq_oe), .dqm_q(mem_byte_mask), .done_q(done));

   assign {mem_sel_n, mem_row_stb_n, mem_col_stb_n, mem_wr_en_n} = cmd_q;
   assign mem_clk_en = 1'b1;
endmodule

// File: rtl/sdr_wr_chk.sv
module sdr_wr_chk #(
   parameter int ADDR_W = 11,
   parameter int AP_BIT = 10,
   parameter int BA_W   = 2,
   parameter int MASK_W = 4,
   parameter int P_WR   = 1,
   parameter int P_PRE  = 6,
   parameter int P_NEXT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              cke,
   input logic [3:0]        cmd,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              oe,
   input logic [MASK_W-1:0] dqm
);
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam int SW = $clog2(P_NEXT + 1);

   logic [SW-1:0]   since_act;
   logic [BA_W-1:0] act_bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act <= SW'(P_NEXT);
         act_bank  <= '0;
      end else if (cmd == C_ACT) begin
         since_act <= SW'(1);
         act_bank  <= ba;
      end else if (since_act != SW'(P_NEXT)) begin
         since_act <= since_act + SW'(1);
      end
   end

   p_accept_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (cmd == C_ACT && !req_ready));
   p_write_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_WR) |-> (since_act == SW'(P_WR) && !addr[AP_BIT] && ba == act_bank));
   p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_WR) |-> oe);
   p_idle_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (dqm == '1));
   p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_PRE) |-> (since_act == SW'(P_PRE) && !addr[AP_BIT] && ba == act_bank));
   p_done_is_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done == (cmd == C_PRE));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_ACT) |-> (since_act == SW'(P_NEXT)));
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> (cmd != C_ACT));
   p_cke_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cke);
endmodule

bind sdr_wr_seq sdr_wr_chk #(
   .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .BA_W(BA_W), .MASK_W(MASK_W),
   .P_WR(P_WR), .P_PRE(P_PRE), .P_NEXT(P_NEXT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .done(done), .cke(mem_clk_en),
   .cmd({mem_sel_n, mem_row_stb_n, mem_col_stb_n, mem_wr_en_n}),
   .addr(mem_addr), .ba(mem_bank), .oe(mem_dq_oe), .dqm(mem_byte_mask));

// File: tb/test_sdr_wr_seq.sv
module test_sdr_wr_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_bank = '0;
   logic [10:0] req_row = '0;
   logic [7:0] req_col = '0;
   logic [127:0] req_data = '0;
   logic [15:0] req_mask = '0;
   logic done, mem_clk_en, mem_sel_n, mem_row_stb_n, mem_col_stb_n, mem_wr_en_n;
   logic [10:0] mem_addr;
   logic [1:0] mem_bank;
   logic [31:0] mem_dq_o;
   logic mem_dq_oe;
   logic [3:0] mem_byte_mask;

   int n_checks = 0;
   int n_fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   sdr_wr_seq i_sdr_wr_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_data(req_data), .req_mask(req_mask), .done(done),
      .mem_clk_en(mem_clk_en), .mem_sel_n(mem_sel_n), .mem_row_stb_n(mem_row_stb_n),
      .mem_col_stb_n(mem_col_stb_n), .mem_wr_en_n(mem_wr_en_n), .mem_addr(mem_addr),
      .mem_bank(mem_bank), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_byte_mask(mem_byte_mask));

   typedef struct packed {
      logic [1:0]  bank;
      logic [10:0] row;
      logic [7:0]  col;
      logic [31:0] seed;
      logic [15:0] mask;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 11'h000, 8'h00, 32'h0000_0000, 16'h0000},
      '{2'd3, 11'h7FF, 8'hFF, 32'hDEAD_BEEF, 16'hA5C3},
      '{2'd1, 11'h2AA, 8'h55, 32'h1234_5678, 16'h0F0F},
      '{2'd2, 11'h555, 8'hAA, 32'hFFFF_FFFF, 16'hFFFF}
   };

   // Expected command timing at defaults: WRITE 1, PRECHARGE 6 after ACTIVE
   localparam int S_WR  = 1;
   localparam int S_PRE = 6;

   function automatic logic [31:0] word_of(vec_t v, int k);
      return v.seed ^ (32'h0101_0101 * (k + 1));
   endfunction

   function automatic logic [127:0] data_of(vec_t v);
      logic [127:0] d;
      for (int k = 0; k < 4; k++) d[32*k +: 32] = word_of(v, k);
      return d;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] cmd_now();
      return {mem_sel_n, mem_row_stb_n, mem_col_stb_n, mem_wr_en_n};
   endfunction

   task automatic issue(input vec_t v);
      req_bank  = v.bank;
      req_row   = v.row;
      req_col   = v.col;
      req_data  = data_of(v);
      req_mask  = v.mask;
      req_valid = 1'b1;
   endtask

   task automatic check_idle(input string tag);
      chk({tag, " R1/R9 cmd NOP"}, 32'(cmd_now()), 32'h7);
      chk({tag, " R1 oe"}, 32'(mem_dq_oe), 32'h0);
      chk({tag, " R1 mask"}, 32'(mem_byte_mask), 32'hF);
      chk({tag, " R1 done"}, 32'(done), 32'h0);
      chk({tag, " R1 ready"}, 32'(req_ready), 32'h1);
      chk({tag, " R9 cke"}, 32'(mem_clk_en), 32'h1);
   endtask

   // Follow one sequence from its ACTIVE slot through PRECHARGE.
   // junk: hold a scrambled request during busy slots (R8).
   // nxt_valid: present the next vector in the PRECHARGE slot (R7).
   task automatic follow(input vec_t v, input bit junk, input bit nxt_valid, input vec_t nxt);
      for (int s = 0; s <= S_PRE; s++) begin
         @(negedge clk);
         if (s == 0) begin
            req_valid = junk;
            if (junk) begin
               req_bank = ~v.bank; req_row = ~v.row; req_col = ~v.col;
               req_data = ~data_of(v); req_mask = ~v.mask;
            end
         end
         chk("R9 cke", 32'(mem_clk_en), 32'h1);
         if (s == 0) begin
            chk("R2 ACTIVE", 32'(cmd_now()), 32'h3);
            chk("R2 row", 32'(mem_addr), 32'(v.row));
            chk("R2 bank", 32'(mem_bank), 32'(v.bank));
         end else if (s == S_WR) begin
            chk("R3 WRITE", 32'(cmd_now()), 32'h4);
            chk("R3 column addr", 32'(mem_addr), 32'(v.col));
            chk("R3 bank", 32'(mem_bank), 32'(v.bank));
         end else if (s == S_PRE) begin
            chk("R5 PRECHARGE", 32'(cmd_now()), 32'h2);
            chk("R5 addr bit 10", 32'(mem_addr[10]), 32'h0);
            chk("R5 bank", 32'(mem_bank), 32'(v.bank));
         end else begin
            chk("R9 NOP", 32'(cmd_now()), 32'h7);
         end
         if (s >= S_WR && s < S_WR + 4) begin
            chk("R4 oe", 32'(mem_dq_oe), 32'h1);
            chk("R4 data", mem_dq_o, word_of(v, s - S_WR));
            chk("R4 byte mask", 32'(mem_byte_mask), 32'(v.mask[4*(s-S_WR) +: 4]));
         end else begin
            chk("R4 oe idle", 32'(mem_dq_oe), 32'h0);
            chk("R4 mask idle", 32'(mem_byte_mask), 32'hF);
         end
         chk("R6 done", 32'(done), (s == S_PRE) ? 32'h1 : 32'h0);
         chk("R7 ready", 32'(req_ready), (s == S_PRE) ? 32'h1 : 32'h0);
         if (s == S_PRE - 1) req_valid = 1'b0;
         if (s == S_PRE && nxt_valid) issue(nxt);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_idle("reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("post-reset");

      // Vector table, back to back (R7: next ACTIVE seven cycles later)
      issue(VECS[0]);
      for (int i = 0; i < NV; i++)
         follow(VECS[i], 1'b0, (i < NV - 1), VECS[(i + 1) % NV]);
      @(negedge clk);
      check_idle("after table R9");

      // R8: requests while ready is low are ignored
      issue(VECS[1]);
      follow(VECS[1], 1'b1, 1'b0, VECS[0]);
      @(negedge clk);
      check_idle("after busy request R8");

      // R10: reset in the middle of a sequence
      issue(VECS[2]);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 ACTIVE before reset", 32'(cmd_now()), 32'h3);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_idle("R10 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R10 after reset");
      issue(VECS[3]);
      follow(VECS[3], 1'b0, 1'b0, VECS[0]);
      repeat (2) @(negedge clk);
      check_idle("R10 final idle");

      summary();
      $finish;
   end
endmodule